// File: doc/BRIEF.md
# Offset-State Decade Counter

This block is a synchronous modulo-10 counter whose 4-bit register never uses the codes 0 to 5. After a clear it holds 6. Each enabled clock adds one until the register reaches 15. The next enabled clock does not wrap to 0. It loads the value 0110, so the register returns to 6. Every cycle of the count therefore covers exactly ten states.

A separate combinational decoder turns the raw register value into a decimal digit from 0 to 9 by taking away the offset of six. The decoder has four inputs and four outputs and no enable. A terminal-count flag marks the single enabled cycle in which the reload from 15 to 6 takes place. Both the raw state and the digit are brought out, so the block can feed logic that wants either form.

Top module: `offset_decade_counter`

## Requirements
- R1: When `clr` is high at a rising edge of `clk`, the state becomes 6 (`0110`) and the digit becomes 0. This holds whatever the value of `cnt_en`.
- R2: When `clr` is low, `cnt_en` is high and the state is between 6 and 14, the state at the next rising edge is the old state plus one.
- R3: When `clr` is low, `cnt_en` is high and the state is 15, the next rising edge loads 6 (`0110`) instead of wrapping to 0. An enabled count from any code below 6 also loads 6.
- R4: When `clr` and `cnt_en` are both low, the state and the digit keep their values across the edge.
- R5: `digit_o` is combinational and equals the state minus six for every state from 6 to 15. State 6 gives 0 and state 15 gives 9.
- R6: `tc_o` is high exactly when the state is 15 and `cnt_en` is high. It is low at 15 while `cnt_en` is low, and low at every other state.
- R7: Starting from a clear, ten enabled clocks bring the state back to 6. `tc_o` is seen high exactly once in those ten cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear to state 6, takes priority over counting |
| cnt_en | input | 1 | Count enable |
| state_o | output | 4 | Raw register value, 6 to 15 in normal use |
| digit_o | output | 4 | Decoded decimal digit, state minus six |
| tc_o | output | 1 | High while the state is 15 and counting is enabled |

## Verification
The bench drives the register up to 15 and checks that the next enabled edge gives 6. A design that wraps to 0, or that loads on 14, would show the wrong state at that point. It also sits at 15 with the enable low. A flag that ignores the enable would show up high there, and a counter that ignores the enable would move. A clear is applied while the enable is high, to catch a design where counting wins over clearing. A full ten-clock loop is run with the flag counted, which exposes a cycle that is nine or eleven long. The digit is checked after every edge, so a decoder with the wrong offset fails on the first step.

// File: rtl/offset_decade_pkg.sv
package offset_decade_pkg;
    localparam int unsigned CNT_W = 4;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t state;
    } ctr_regs_t;
endpackage

// File: rtl/offset_decade_core.sv
module offset_decade_core
    import offset_decade_pkg::*;
#(
    parameter int unsigned BASE_VAL = 6,
    parameter int unsigned MODULUS  = 10
) (
    input  logic clk,
    input  logic clr,
    input  logic cnt_en,
    output cnt_t state_o,
    output logic tc_o
);
    localparam cnt_t BASE_S = CNT_W'(BASE_VAL);
    localparam cnt_t TOP_S  = CNT_W'(BASE_VAL + MODULUS - 1);

    ctr_regs_t regs_d;
    ctr_regs_t regs_q;

    logic at_top;
    logic below_base;

    assign at_top     = (regs_q.state == TOP_S);
    assign below_base = (regs_q.state < BASE_S);

    always_comb begin
        regs_d = regs_q;
        if (clr) begin
            regs_d.state = BASE_S;
        end else if (cnt_en) begin
            if (at_top || below_base) begin
                regs_d.state = BASE_S;
            end else begin
                regs_d.state = regs_q.state + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign state_o = regs_q.state;
    assign tc_o    = at_top && cnt_en;

    p_clear_base_r1: assert property (@(posedge clk)
        clr |=> (state_o == BASE_S));

    p_step_r2: assert property (@(posedge clk) disable iff (clr)
        (cnt_en && (state_o >= BASE_S) && (state_o < TOP_S))
        |=> (state_o == $past(state_o) + 1'b1));

    p_reload_r3: assert property (@(posedge clk) disable iff (clr)
        (cnt_en && ((state_o == TOP_S) || (state_o < BASE_S)))
        |=> (state_o == BASE_S));

    p_hold_r4: assert property (@(posedge clk) disable iff (clr)
        !cnt_en |=> $stable(state_o));

    p_tc_reload_r6: assert property (@(posedge clk) disable iff (clr)
        tc_o |=> (state_o == BASE_S));
endmodule

// File: rtl/offset_decade_decoder.sv
module offset_decade_decoder
    import offset_decade_pkg::*;
#(
    parameter int unsigned BASE_VAL = 6,
    parameter int unsigned DIGIT_W  = 4
) (
    input  cnt_t               code_i,
    output logic [DIGIT_W-1:0] digit_o
);
    localparam cnt_t OFFSET_S = CNT_W'(BASE_VAL);

    cnt_t diff;

    always_comb begin
        diff    = code_i - OFFSET_S;
        digit_o = DIGIT_W'(diff);
    end
endmodule

// File: rtl/offset_decade_counter.sv
module offset_decade_counter
    import offset_decade_pkg::*;
#(
    parameter int unsigned BASE_VAL = 6,
    parameter int unsigned MODULUS  = 10,
    parameter int unsigned DIGIT_W  = 4
) (
    input  logic               clk,
    input  logic               clr,
    input  logic               cnt_en,
    output logic [CNT_W-1:0]   state_o,
    output logic [DIGIT_W-1:0] digit_o,
    output logic               tc_o
);
    localparam cnt_t BASE_S = CNT_W'(BASE_VAL);
    localparam logic [DIGIT_W-1:0] DMAX = DIGIT_W'(MODULUS - 1);

    cnt_t state_w;

    offset_decade_core #(
        .BASE_VAL(BASE_VAL),
        .MODULUS (MODULUS)
    ) core_i (
        .clk    (clk),
        .clr    (clr),
        .cnt_en (cnt_en),
        .state_o(state_w),
        .tc_o   (tc_o)
    );

    offset_decade_decoder #(
        .BASE_VAL(BASE_VAL),
        .DIGIT_W (DIGIT_W)
    ) dec_i (
        .code_i (state_w),
        .digit_o(digit_o)
    );

    assign state_o = state_w;

    p_digit_range_r5: assert property (@(posedge clk) disable iff (clr)
        (state_o >= BASE_S) |-> (digit_o <= DMAX));

    p_digit_tracks_r5: assert property (@(posedge clk) disable iff (clr)
        (cnt_en && (digit_o < DMAX) && (state_o >= BASE_S))
        |=> (digit_o == $past(digit_o) + 1'b1));
endmodule

// File: tb/offset_decade_counter_tb.sv
module offset_decade_counter_tb_top;
    logic       clk = 1'b0;
    logic       clr = 1'b0;
    logic       cnt_en = 1'b0;
    logic [3:0] state_o;
    logic [3:0] digit_o;
    logic       tc_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    offset_decade_counter dut_i (
        .clk    (clk),
        .clr    (clr),
        .cnt_en (cnt_en),
        .state_o(state_o),
        .digit_o(digit_o),
        .tc_o   (tc_o)
    );

    // vector bit order: {clr, cnt_en, tc before the edge, state after the edge}
    localparam logic [6:0] VEC [20] = '{
        {2'b01, 1'b0, 4'd7},  {2'b01, 1'b0, 4'd8},
        {2'b00, 1'b0, 4'd8},  {2'b01, 1'b0, 4'd9},
        {2'b01, 1'b0, 4'd10}, {2'b01, 1'b0, 4'd11},
        {2'b01, 1'b0, 4'd12}, {2'b11, 1'b0, 4'd6},
        {2'b01, 1'b0, 4'd7},  {2'b01, 1'b0, 4'd8},
        {2'b01, 1'b0, 4'd9},  {2'b01, 1'b0, 4'd10},
        {2'b01, 1'b0, 4'd11}, {2'b01, 1'b0, 4'd12},
        {2'b01, 1'b0, 4'd13}, {2'b01, 1'b0, 4'd14},
        {2'b01, 1'b0, 4'd15}, {2'b00, 1'b0, 4'd15},
        {2'b01, 1'b1, 4'd6},  {2'b01, 1'b0, 4'd7}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input logic c, input logic e);
        @(negedge clk);
        clr = c;
        cnt_en = e;
        #1;
    endtask

    initial begin
        int tc_seen;
        // R1: reset state
        step(1'b1, 1'b0);
        @(posedge clk); #1;
        chk("R1 state after clear", state_o, 6);
        chk("R1 digit after clear", digit_o, 0);

        for (int i = 0; i < 20; i++) begin
            step(VEC[i][6], VEC[i][5]);
            // R6: flag sampled before the edge
            chk("R6 tc", tc_o, VEC[i][4]);
            @(posedge clk); #1;
            // R2 R3 R4 R1 via table
            chk("R2/R3/R4 state", state_o, VEC[i][3:0]);
            // R5: decoded digit
            chk("R5 digit", digit_o, VEC[i][3:0] - 6);
        end

        // R7: full loop of ten enabled clocks
        step(1'b1, 1'b0);
        @(posedge clk); #1;
        tc_seen = 0;
        for (int k = 0; k < 10; k++) begin
            step(1'b0, 1'b1);
            if (tc_o) tc_seen++;
            @(posedge clk); #1;
        end
        chk("R7 state after ten counts", state_o, 6);
        chk("R7 tc pulses per loop", tc_seen, 1);

        // R3 and R5: top state decodes to 9, then reload
        for (int k = 0; k < 9; k++) begin
            step(1'b0, 1'b1);
            @(posedge clk); #1;
        end
        chk("R5 digit at top", digit_o, 9);
        chk("R3 state at top", state_o, 15);

        // R1: clear at 15 with enable low
        step(1'b1, 1'b0);
        chk("R6 tc low without enable", tc_o, 0);
        @(posedge clk); #1;
        chk("R1 clear from top", state_o, 6);

        // R4: long hold
        for (int k = 0; k < 5; k++) begin
            step(1'b0, 1'b0);
            @(posedge clk); #1;
        end
        chk("R4 hold", state_o, 6);
        chk("R4 hold digit", digit_o, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule